// File: doc/BRIEF.md
# Deferred load fault tracker

This block keeps the bookkeeping for loads that a CPU issues speculatively and whose faults must not trap at once. Each architectural register, integer and floating alike, has a poison flag. A fault found during such a load, or a poisoned source register feeding it, marks the destination register instead of trapping. When record-keeping is on, every reported load also takes a slot from a small pool. The slot holds the fault reason, the destination, the access size and the address.

Software later issues a commit on a register or on a whole class. If the commit finds poison and record-keeping is on, the block raises a commit exception interrupt. A clear command drops poison quietly. A divide unit reports its faults on a separate port. A masked overflow becomes a sticky accrued bit. Any other cause either poisons the integer destination or raises a division interrupt. Flags and slots can be read back at any time for the trap handler.

Top module: `ldft_tracker`

## Requirements
- R1: After reset every poison flag is 0, every slot is invalid, and `commit_irq`, `div_irq` and `acc_sticky` are 0.
- R2: Integer and floating flags are separate banks. The bank is chosen by `ld_fp` or `cmd_fp` (1 = floating), and an operation on one bank leaves the other bank unchanged.
- R3: Record-keeping is on when `ctl_valid` and `ctl_keep` are both 1. While it is on, each accepted load fills the lowest-numbered invalid slot. The slot gets valid=1, address-valid=1, destination, size, its own slot number, the float marker and the address. While it is off, no slot is written.
- R4: If record-keeping is on and all slots are valid, `ld_abort` goes high in the same cycle as `ld_valid` and `ld_go` stays low. No flag and no slot changes.
- R5: A register-misalignment fault or a memory-misalignment fault sets the destination flag and holds `ld_go` low. The slot's register-reason field reads 1 for a register misalignment and 0 otherwise. Its memory-reason field reads 2 for a memory misalignment and 0 otherwise.
- R6: A fault-free load copies poison to the destination when the base flag is set, or when `ld_disp_vld` is 1 and the displacement flag is set. In that case `ld_go` is 0. Otherwise the load clears the destination flag and `ld_go` is 1 in the same cycle.
- R7: A clear command with `cmd_all`=0 clears flag `cmd_idx`. With `cmd_all`=1 it clears every flag in the enabled halves: indices 32..63 need `avail_hi`, and 0..31 need `avail_lo`. A command on a single index in a disabled half has no effect.
- R8: While record-keeping is on, a clear command invalidates every valid slot of the same class whose destination equals `cmd_idx`, or every slot of that class when `cmd_all`=1, and zeroes its address.
- R9: A commit samples the target flag, or any flag in the enabled halves, before clearing the flags as R7 does. If the sample was set and record-keeping is on, it invalidates slots as R8 does and pulses `commit_irq` for one cycle, one cycle after the command.
- R10: A divide report with `dv_ovf` and `dv_ovf_mask` both set drops the overflow cause and sets `acc_sticky`, which stays set until reset.
- R11: If a divide cause remains after R10, `dv_nonexc`=1 sets the integer flag `dv_dst`. Otherwise `div_irq` pulses for one cycle, one cycle after the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_valid | input | 1 | Control setting valid |
| ctl_keep | input | 1 | Record-keeping enable |
| ld_valid | input | 1 | Load report strobe |
| ld_fp | input | 1 | Load targets the floating bank |
| ld_dst | input | 6 | Destination register |
| ld_base | input | 6 | Base source register |
| ld_disp_vld | input | 1 | Displacement register in use |
| ld_disp | input | 6 | Displacement source register |
| ld_size | input | 3 | Access size in bytes |
| ld_addr | input | 32 | Access address |
| ld_reg_misal | input | 1 | Register misalignment fault |
| ld_mem_misal | input | 1 | Memory misalignment fault |
| ld_go | output | 1 | Load may proceed (combinational) |
| ld_abort | output | 1 | No free slot (combinational) |
| cmd_valid | input | 1 | Command strobe |
| cmd_commit | input | 1 | 1 = commit, 0 = clear |
| cmd_fp | input | 1 | Command targets the floating bank |
| cmd_all | input | 1 | Whole class instead of one register |
| cmd_idx | input | 6 | Target register |
| avail_hi | input | 1 | Upper half (32..63) enabled |
| avail_lo | input | 1 | Lower half (0..31) enabled |
| dv_valid | input | 1 | Divide fault report strobe |
| dv_ovf | input | 1 | Overflow cause |
| dv_other | input | 1 | Other cause (e.g. zero divisor) |
| dv_ovf_mask | input | 1 | Overflow masked to sticky bit |
| dv_nonexc | input | 1 | Non-excepting divide |
| dv_dst | input | 6 | Divide destination register |
| rb_fp | input | 1 | Flag readback bank |
| rb_idx | input | 6 | Flag readback index |
| rb_flag | output | 1 | Flag readback value |
| rb_slot | input | 3 | Slot readback index |
| rb_s_valid | output | 1 | Slot valid |
| rb_s_avld | output | 1 | Slot address valid |
| rb_s_dst | output | 6 | Slot destination |
| rb_s_size | output | 3 | Slot access size |
| rb_s_own | output | 3 | Slot's own index |
| rb_s_fp | output | 1 | Slot float marker |
| rb_s_regrsn | output | 2 | Register-misalignment reason |
| rb_s_memrsn | output | 2 | Memory-misalignment reason |
| rb_s_addr | output | 32 | Slot address |
| commit_irq | output | 1 | Commit exception request pulse |
| div_irq | output | 1 | Division exception request pulse |
| acc_sticky | output | 1 | Accrued masked-overflow bit |

## Verification
A wrong flag shows up at the ports in two ways. It changes `ld_go` in the same cycle when a later load uses that register as a source, and it changes `commit_irq` one cycle after a commit on that register. A corrupt slot vector shows as a wrong slot number for the next allocation, or as a false or missing `ld_abort`, in the cycle of the next load report. Stale or missing slot clears show up on the slot readback at the first idle cycle after the command. The bench uses a full pool, both halves of the bank, both classes and record-keeping switched off so that each of these paths is exposed.

// File: rtl/ldft_pkg.sv
package ldft_pkg;
    parameter int NREG  = 64;
    parameter int NSLOT = 8;
    parameter int AW    = 32;
    parameter int SZW   = 3;

    localparam int RW    = $clog2(NREG);
    localparam int SW    = $clog2(NSLOT);
    localparam int HALF  = NREG / 2;
    localparam int NCLS  = 2;

    typedef enum logic [1:0] {
        RSN_NONE      = 2'd0,
        RSN_REG_MISAL = 2'd1,
        RSN_MEM_MISAL = 2'd2
    } rsn_e;

    typedef struct packed {
        logic           vld;
        logic           avld;
        logic [RW-1:0]  dst;
        logic [SZW-1:0] size;
        logic [SW-1:0]  own;
        logic           fp;
        rsn_e           reg_rsn;
        rsn_e           mem_rsn;
    } slot_rec_t;

    // Mask of flags covered by the enabled halves of a bank.
    function automatic logic [NREG-1:0] half_mask(input logic hi, input logic lo);
        logic [NREG-1:0] m;
        m = '0;
        for (int i = 0; i < NREG; i++) m[i] = (i >= HALF) ? hi : lo;
        return m;
    endfunction

    // Lowest-index unused slot.
    function automatic logic [SW-1:0] first_free(input logic [NSLOT-1:0] used);
        logic [SW-1:0] r;
        r = '0;
        for (int i = NSLOT - 1; i >= 0; i--) if (!used[i]) r = SW'(i);
        return r;
    endfunction
endpackage

// File: rtl/ldft_flag_bank.sv
module ldft_flag_bank
    import ldft_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic [RW-1:0]   ld_dst,
    input  logic [RW-1:0]   ld_base,
    input  logic            ld_disp_vld,
    input  logic [RW-1:0]   ld_disp,
    input  logic            ld_fault,
    input  logic            dv_set,
    input  logic [RW-1:0]   dv_dst,
    input  logic            cmd_en,
    input  logic            cmd_all,
    input  logic [RW-1:0]   cmd_idx,
    input  logic [NREG-1:0] cmd_mask,
    input  logic [RW-1:0]   rd_idx,
    output logic            rd_flag,
    output logic            src_poison,
    output logic            cmd_pending,
    output logic [NREG-1:0] flags
);
    logic [NREG-1:0] flags_q;
    logic [NREG-1:0] flags_d;

    assign flags       = flags_q;
    assign rd_flag     = flags_q[rd_idx];
    assign src_poison  = flags_q[ld_base] | (ld_disp_vld & flags_q[ld_disp]);
    assign cmd_pending = cmd_all ? |(flags_q & cmd_mask) : flags_q[cmd_idx];

    // Load and divide updates first, command clears last.
    always_comb begin
        flags_d = flags_q;
        if (ld_en)  flags_d[ld_dst] = ld_fault | src_poison;
        if (dv_set) flags_d[dv_dst] = 1'b1;
        if (cmd_en) begin
            if (cmd_all) flags_d = flags_d & ~cmd_mask;
            else         flags_d[cmd_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end
endmodule

// File: rtl/ldft_slot_pool.sv
module ldft_slot_pool
    import ldft_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  slot_rec_t        alloc_rec,
    input  logic [AW-1:0]    alloc_addr,
    input  logic             clr_en,
    input  logic             clr_fp,
    input  logic             clr_all,
    input  logic [RW-1:0]    clr_idx,
    input  logic [SW-1:0]    rd_slot,
    output slot_rec_t        rd_rec,
    output logic [AW-1:0]    rd_addr,
    output logic             free_any,
    output logic [NSLOT-1:0] used_vec
);
    logic [SW-1:0] alloc_idx;
    slot_rec_t     wr_rec;
    slot_rec_t     rec_arr  [NSLOT];
    logic [AW-1:0] addr_arr [NSLOT];

    assign alloc_idx = first_free(used_vec);
    assign free_any  = ~&used_vec;

    always_comb begin
        wr_rec     = alloc_rec;
        wr_rec.vld = 1'b1;
        wr_rec.own = alloc_idx;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        slot_rec_t     rec_q;
        logic [AW-1:0] addr_q;
        logic          hit;

        assign hit = clr_en && rec_q.vld && (rec_q.fp == clr_fp)
                     && (clr_all || (rec_q.dst == clr_idx));

        always_ff @(posedge clk) begin
            if (rst) begin
                rec_q  <= '0;
                addr_q <= '0;
            end else if (alloc_en && (alloc_idx == SW'(s)) && !rec_q.vld) begin
                rec_q  <= wr_rec;
                addr_q <= alloc_addr;
            end else if (hit) begin
                rec_q  <= '0;
                addr_q <= '0;
            end
        end

        assign used_vec[s] = rec_q.vld;
        assign rec_arr[s]  = rec_q;
        assign addr_arr[s] = addr_q;
    end

    assign rd_rec  = rec_arr[rd_slot];
    assign rd_addr = addr_arr[rd_slot];
endmodule

// File: rtl/ldft_tracker.sv
module ldft_tracker
    import ldft_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           ctl_valid,
    input  logic           ctl_keep,
    input  logic           ld_valid,
    input  logic           ld_fp,
    input  logic [5:0]     ld_dst,
    input  logic [5:0]     ld_base,
    input  logic           ld_disp_vld,
    input  logic [5:0]     ld_disp,
    input  logic [2:0]     ld_size,
    input  logic [31:0]    ld_addr,
    input  logic           ld_reg_misal,
    input  logic           ld_mem_misal,
    output logic           ld_go,
    output logic           ld_abort,
    input  logic           cmd_valid,
    input  logic           cmd_commit,
    input  logic           cmd_fp,
    input  logic           cmd_all,
    input  logic [5:0]     cmd_idx,
    input  logic           avail_hi,
    input  logic           avail_lo,
    input  logic           dv_valid,
    input  logic           dv_ovf,
    input  logic           dv_other,
    input  logic           dv_ovf_mask,
    input  logic           dv_nonexc,
    input  logic [5:0]     dv_dst,
    input  logic           rb_fp,
    input  logic [5:0]     rb_idx,
    output logic           rb_flag,
    input  logic [2:0]     rb_slot,
    output logic           rb_s_valid,
    output logic           rb_s_avld,
    output logic [5:0]     rb_s_dst,
    output logic [2:0]     rb_s_size,
    output logic [2:0]     rb_s_own,
    output logic           rb_s_fp,
    output logic [1:0]     rb_s_regrsn,
    output logic [1:0]     rb_s_memrsn,
    output logic [31:0]    rb_s_addr,
    output logic           commit_irq,
    output logic           div_irq,
    output logic           acc_sticky
);
    logic            keep;
    logic            ld_fault;
    logic            ld_acc;
    logic            free_any;
    logic [NSLOT-1:0] slot_used;
    logic            cmd_ok;
    logic            pending;
    logic            src_poison;
    logic [NREG-1:0] cmd_mask;
    logic            dv_cause;
    logic            dv_flag_set;
    logic            clr_en;
    logic [NCLS-1:0] poison_c;
    logic [NCLS-1:0] pend_c;
    logic [NCLS-1:0] rdf_c;
    logic [NREG-1:0] flg_c [NCLS];
    logic [NREG-1:0] int_flags;
    logic [NREG-1:0] fp_flags;
    slot_rec_t       new_rec;
    slot_rec_t       rd_rec;

    assign keep     = ctl_valid & ctl_keep;
    assign ld_fault = ld_reg_misal | ld_mem_misal;
    assign ld_abort = ld_valid & keep & ~free_any;
    assign ld_acc   = ld_valid & ~ld_abort;
    assign cmd_mask = half_mask(avail_hi, avail_lo);
    assign cmd_ok   = cmd_valid & (cmd_all | (cmd_idx[RW-1] ? avail_hi : avail_lo));

    assign dv_cause    = (dv_ovf & ~dv_ovf_mask) | dv_other;
    assign dv_flag_set = dv_valid & dv_cause & dv_nonexc;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        ldft_flag_bank u_bank (
            .clk         (clk),
            .rst         (rst),
            .ld_en       (ld_acc && (ld_fp == c[0])),
            .ld_dst      (ld_dst),
            .ld_base     (ld_base),
            .ld_disp_vld (ld_disp_vld),
            .ld_disp     (ld_disp),
            .ld_fault    (ld_fault),
            .dv_set      ((c == 0) && dv_flag_set),
            .dv_dst      (dv_dst),
            .cmd_en      (cmd_ok && (cmd_fp == c[0])),
            .cmd_all     (cmd_all),
            .cmd_idx     (cmd_idx),
            .cmd_mask    (cmd_mask),
            .rd_idx      (rb_idx),
            .rd_flag     (rdf_c[c]),
            .src_poison  (poison_c[c]),
            .cmd_pending (pend_c[c]),
            .flags       (flg_c[c])
        );
    end

    assign int_flags  = flg_c[0];
    assign fp_flags   = flg_c[1];
    assign src_poison = poison_c[ld_fp];
    assign pending    = pend_c[cmd_fp];
    assign rb_flag    = rdf_c[rb_fp];
    assign ld_go      = ld_acc & ~ld_fault & ~src_poison;

    always_comb begin
        new_rec         = '0;
        new_rec.vld     = 1'b1;
        new_rec.avld    = 1'b1;
        new_rec.dst     = ld_dst;
        new_rec.size    = ld_size;
        new_rec.fp      = ld_fp;
        new_rec.reg_rsn = ld_reg_misal ? RSN_REG_MISAL : RSN_NONE;
        new_rec.mem_rsn = ld_mem_misal ? RSN_MEM_MISAL : RSN_NONE;
    end

    assign clr_en = cmd_ok & keep & (~cmd_commit | pending);

    ldft_slot_pool u_pool (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (ld_acc & keep),
        .alloc_rec  (new_rec),
        .alloc_addr (ld_addr),
        .clr_en     (clr_en),
        .clr_fp     (cmd_fp),
        .clr_all    (cmd_all),
        .clr_idx    (cmd_idx),
        .rd_slot    (rb_slot),
        .rd_rec     (rd_rec),
        .rd_addr    (rb_s_addr),
        .free_any   (free_any),
        .used_vec   (slot_used)
    );

    assign rb_s_valid  = rd_rec.vld;
    assign rb_s_avld   = rd_rec.avld;
    assign rb_s_dst    = rd_rec.dst;
    assign rb_s_size   = rd_rec.size;
    assign rb_s_own    = rd_rec.own;
    assign rb_s_fp     = rd_rec.fp;
    assign rb_s_regrsn = rd_rec.reg_rsn;
    assign rb_s_memrsn = rd_rec.mem_rsn;

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_irq <= 1'b0;
            div_irq    <= 1'b0;
            acc_sticky <= 1'b0;
        end else begin
            commit_irq <= cmd_ok & cmd_commit & pending & keep;
            div_irq    <= dv_valid & dv_cause & ~dv_nonexc;
            acc_sticky <= acc_sticky | (dv_valid & dv_ovf & dv_ovf_mask);
        end
    end
endmodule

// File: rtl/ldft_checker.sv
module ldft_checker
    import ldft_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ld_valid,
    input logic             ld_fp,
    input logic [RW-1:0]    ld_dst,
    input logic             ld_reg_misal,
    input logic             ld_mem_misal,
    input logic             ld_go,
    input logic             ld_abort,
    input logic             cmd_valid,
    input logic             cmd_commit,
    input logic             dv_valid,
    input logic             dv_nonexc,
    input logic             commit_irq,
    input logic             div_irq,
    input logic             acc_sticky,
    input logic [NSLOT-1:0] slot_used,
    input logic [NREG-1:0]  int_flags,
    input logic [NREG-1:0]  fp_flags
);
    assert_abort_full_R4: assert property (@(posedge clk) disable iff (rst)
        ld_abort |-> (&slot_used));

    assert_abort_keeps_slots_R4: assert property (@(posedge clk) disable iff (rst)
        (ld_abort && !cmd_valid) |=> $stable(slot_used));

    assert_fault_blocks_go_R5: assert property (@(posedge clk) disable iff (rst)
        ld_go |-> !(ld_reg_misal || ld_mem_misal || ld_abort));

    assert_fault_poisons_R5: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_abort && (ld_reg_misal || ld_mem_misal) && !cmd_valid)
        |=> ($past(ld_fp) ? fp_flags[$past(ld_dst)] : int_flags[$past(ld_dst)]));

    assert_commit_irq_src_R9: assert property (@(posedge clk) disable iff (rst)
        commit_irq |-> $past(cmd_valid && cmd_commit));

    assert_clear_no_irq_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_commit) |=> !commit_irq);

    assert_sticky_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !$fell(acc_sticky));

    assert_div_irq_src_R11: assert property (@(posedge clk) disable iff (rst)
        div_irq |-> $past(dv_valid && !dv_nonexc));
endmodule

bind ldft_tracker ldft_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .ld_valid     (ld_valid),
    .ld_fp        (ld_fp),
    .ld_dst       (ld_dst),
    .ld_reg_misal (ld_reg_misal),
    .ld_mem_misal (ld_mem_misal),
    .ld_go        (ld_go),
    .ld_abort     (ld_abort),
    .cmd_valid    (cmd_valid),
    .cmd_commit   (cmd_commit),
    .dv_valid     (dv_valid),
    .dv_nonexc    (dv_nonexc),
    .commit_irq   (commit_irq),
    .div_irq      (div_irq),
    .acc_sticky   (acc_sticky),
    .slot_used    (slot_used),
    .int_flags    (int_flags),
    .fp_flags     (fp_flags)
);

// File: tb/ldft_tracker_bench.sv
`timescale 1ns/1ps
module ldft_tracker_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_valid = 1'b1, ctl_keep = 1'b1;
    logic ld_valid = 0, ld_fp = 0, ld_disp_vld = 0, ld_reg_misal = 0, ld_mem_misal = 0;
    logic [5:0] ld_dst = 0, ld_base = 0, ld_disp = 0;
    logic [2:0] ld_size = 0;
    logic [31:0] ld_addr = 0;
    logic ld_go, ld_abort;
    logic cmd_valid = 0, cmd_commit = 0, cmd_fp = 0, cmd_all = 0, avail_hi = 1, avail_lo = 1;
    logic [5:0] cmd_idx = 0;
    logic dv_valid = 0, dv_ovf = 0, dv_other = 0, dv_ovf_mask = 0, dv_nonexc = 0;
    logic [5:0] dv_dst = 0;
    logic rb_fp = 0;
    logic [5:0] rb_idx = 0;
    logic rb_flag;
    logic [2:0] rb_slot = 0;
    logic rb_s_valid, rb_s_avld, rb_s_fp;
    logic [5:0] rb_s_dst;
    logic [2:0] rb_s_size, rb_s_own;
    logic [1:0] rb_s_regrsn, rb_s_memrsn;
    logic [31:0] rb_s_addr;
    logic commit_irq, div_irq, acc_sticky;

    int total = 0;
    int bad = 0;
    string exp_q[$];

    always #2 clk = ~clk;

    ldft_tracker u_ldft_tracker (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor: pops expected interrupt events as the design raises them.
    always @(negedge clk) begin
        if (!rst) begin
            if (commit_irq) begin
                if (exp_q.size() == 0) chk("R9 unexpected commit_irq", 1, 0);
                else chk("R9 commit_irq order", (exp_q.pop_front() == "C"), 1);
            end
            if (div_irq) begin
                if (exp_q.size() == 0) chk("R11 unexpected div_irq", 1, 0);
                else chk("R11 div_irq order", (exp_q.pop_front() == "D"), 1);
            end
        end
    end

    task automatic do_load(input logic fp, input logic [5:0] dst, input logic [5:0] base,
                           input logic dvld, input logic [5:0] disp, input logic [2:0] size,
                           input logic [31:0] addr, input logic rm, input logic mm,
                           input logic exp_go, input logic exp_abort, input string tag);
        @(negedge clk);
        ld_valid = 1; ld_fp = fp; ld_dst = dst; ld_base = base; ld_disp_vld = dvld;
        ld_disp = disp; ld_size = size; ld_addr = addr; ld_reg_misal = rm; ld_mem_misal = mm;
        #0.5;
        chk({tag, " ld_go"}, ld_go, exp_go);
        chk({tag, " ld_abort"}, ld_abort, exp_abort);
        @(negedge clk);
        ld_valid = 0; ld_reg_misal = 0; ld_mem_misal = 0;
    endtask

    task automatic do_cmd(input logic commit, input logic fp, input logic all,
                          input logic [5:0] idx, input logic hi, input logic lo,
                          input logic exp_irq, input string tag);
        @(negedge clk);
        cmd_valid = 1; cmd_commit = commit; cmd_fp = fp; cmd_all = all; cmd_idx = idx;
        avail_hi = hi; avail_lo = lo;
        if (exp_irq) exp_q.push_back("C");
        @(negedge clk);
        cmd_valid = 0; avail_hi = 1; avail_lo = 1;
        chk({tag, " commit_irq"}, commit_irq, exp_irq);
    endtask

    task automatic do_div(input logic ovf, input logic other, input logic mask,
                          input logic nonexc, input logic [5:0] dst,
                          input logic exp_irq, input string tag);
        @(negedge clk);
        dv_valid = 1; dv_ovf = ovf; dv_other = other; dv_ovf_mask = mask;
        dv_nonexc = nonexc; dv_dst = dst;
        if (exp_irq) exp_q.push_back("D");
        @(negedge clk);
        dv_valid = 0;
        chk({tag, " div_irq"}, div_irq, exp_irq);
    endtask

    task automatic flag_is(input logic fp, input logic [5:0] idx, input logic exp, input string tag);
        @(negedge clk);
        rb_fp = fp; rb_idx = idx;
        #0.5;
        chk(tag, rb_flag, exp);
    endtask

    task automatic slot_vld(input logic [2:0] s, input logic exp, input string tag);
        @(negedge clk);
        rb_slot = s;
        #0.5;
        chk(tag, rb_s_valid, exp);
    endtask

    task automatic slot_is(input logic [2:0] s, input logic [5:0] dst, input logic fp,
                           input logic [1:0] rr, input logic [1:0] mr,
                           input logic [31:0] addr, input string tag);
        @(negedge clk);
        rb_slot = s;
        #0.5;
        chk({tag, " valid"}, rb_s_valid, 1);
        chk({tag, " avld"}, rb_s_avld, 1);
        chk({tag, " dst"}, rb_s_dst, dst);
        chk({tag, " own"}, rb_s_own, s);
        chk({tag, " fp"}, rb_s_fp, fp);
        chk({tag, " regrsn"}, rb_s_regrsn, rr);
        chk({tag, " memrsn"}, rb_s_memrsn, mr);
        chk({tag, " addr"}, rb_s_addr, addr);
    endtask

    initial begin
        #(4 * 20000);
        chk("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        flag_is(0, 5, 0, "R1 int flag");
        slot_vld(0, 0, "R1 slot0");
        chk("R1 sticky", acc_sticky, 0);
        chk("R1 commit_irq", commit_irq, 0);
        chk("R1 div_irq", div_irq, 0);

        // R5 memory misalignment, integer
        do_load(0, 5, 1, 0, 0, 3'd4, 32'h1000_0002, 0, 1, 0, 0, "R5 int mem fault");
        flag_is(0, 5, 1, "R5 int flag 5 set");
        flag_is(1, 5, 0, "R2 fp flag 5 untouched");
        slot_is(0, 5, 0, 2'd0, 2'd2, 32'h1000_0002, "R3 slot0");
        chk("R3 slot0 size", rb_s_size, 3'd4);

        // R5 register misalignment, floating
        do_load(1, 7, 1, 0, 0, 3'd4, 32'h0000_2000, 1, 0, 0, 0, "R5 fp reg fault");
        flag_is(1, 7, 1, "R2 fp flag 7 set");
        flag_is(0, 7, 0, "R2 int flag 7 untouched");
        slot_is(1, 7, 1, 2'd1, 2'd0, 32'h0000_2000, "R5 slot1");

        // R6 poison through base and through displacement
        do_load(0, 9, 5, 0, 0, 3'd4, 32'h30, 0, 0, 0, 0, "R6 base poison");
        flag_is(0, 9, 1, "R6 flag 9 inherits");
        do_load(0, 10, 1, 1, 9, 3'd4, 32'h40, 0, 0, 0, 0, "R6 disp poison");
        flag_is(0, 10, 1, "R6 flag 10 inherits");
        do_load(0, 11, 1, 0, 9, 3'd2, 32'h50, 0, 0, 1, 0, "R6 disp unused");
        flag_is(0, 11, 0, "R6 flag 11 clean");

        // fill remaining slots, then R4 abort
        do_load(0, 20, 1, 0, 0, 3'd1, 32'h60, 0, 0, 1, 0, "R3 fill5");
        do_load(0, 21, 1, 0, 0, 3'd1, 32'h64, 0, 0, 1, 0, "R3 fill6");
        do_load(0, 22, 1, 0, 0, 3'd1, 32'h68, 0, 0, 1, 0, "R3 fill7");
        slot_is(7, 22, 0, 2'd0, 2'd0, 32'h68, "R3 slot7");
        do_load(0, 23, 1, 0, 0, 3'd4, 32'h70, 0, 1, 0, 1, "R4 pool full");
        flag_is(0, 23, 0, "R4 flag 23 unchanged");
        slot_is(7, 22, 0, 2'd0, 2'd0, 32'h68, "R4 slot7 kept");

        // R7/R8 clear one register
        do_cmd(0, 0, 0, 9, 1, 1, 0, "R7 clear 9");
        flag_is(0, 9, 0, "R7 flag 9 cleared");
        flag_is(0, 10, 1, "R7 flag 10 kept");
        slot_vld(2, 0, "R8 slot2 freed");
        slot_vld(3, 1, "R8 slot3 kept");

        // R9 commit with pending flag
        do_cmd(1, 0, 0, 5, 1, 1, 1, "R9 commit 5");
        flag_is(0, 5, 0, "R9 flag 5 cleared");
        slot_vld(0, 0, "R9 slot0 freed");

        // R3 lowest free slot wins (0 and 2 free)
        do_load(0, 30, 1, 0, 0, 3'd4, 32'h80, 0, 0, 1, 0, "R3 realloc");
        slot_is(0, 30, 0, 2'd0, 2'd0, 32'h80, "R3 lowest free slot0");

        // R9 commit without pending flag
        do_cmd(1, 0, 0, 11, 1, 1, 0, "R9 commit clean 11");
        slot_vld(4, 1, "R9 slot4 kept");

        // R9 commit whole floating class
        do_cmd(1, 1, 1, 0, 1, 1, 1, "R9 commit fp all");
        flag_is(1, 7, 0, "R9 fp flag 7 cleared");
        slot_vld(1, 0, "R9 slot1 freed");
        flag_is(0, 10, 1, "R2 int flag 10 kept");

        // R7 availability of halves
        do_load(0, 40, 1, 0, 0, 3'd4, 32'h90, 0, 1, 0, 0, "R5 upper half fault");
        slot_is(1, 40, 0, 2'd0, 2'd2, 32'h90, "R3 slot1 reuse");
        do_cmd(0, 0, 0, 40, 0, 1, 0, "R7 clear disabled half");
        flag_is(0, 40, 1, "R7 flag 40 kept");
        slot_vld(1, 1, "R7 slot1 kept");
        do_cmd(0, 0, 1, 0, 0, 1, 0, "R7 clear all low half");
        flag_is(0, 10, 0, "R7 flag 10 cleared");
        flag_is(0, 40, 1, "R7 flag 40 upper kept");
        slot_vld(1, 0, "R8 slot1 class clear");
        slot_vld(3, 0, "R8 slot3 class clear");

        // record-keeping off
        ctl_keep = 0;
        do_load(0, 12, 1, 0, 0, 3'd4, 32'hA0, 0, 1, 0, 0, "R3 keep off load");
        flag_is(0, 12, 1, "R5 flag 12 set");
        slot_vld(0, 0, "R3 no alloc when off");
        do_cmd(1, 0, 0, 12, 1, 1, 0, "R9 commit keep off");
        flag_is(0, 12, 0, "R9 flag 12 cleared");
        ctl_keep = 1;

        // divide faults
        do_div(1, 0, 1, 0, 0, 0, "R10 masked ovf");
        chk("R10 sticky set", acc_sticky, 1);
        do_div(0, 1, 0, 1, 13, 0, "R11 nonexc");
        flag_is(0, 13, 1, "R11 flag 13 set");
        do_div(0, 1, 0, 0, 14, 1, "R11 div zero irq");
        flag_is(0, 14, 0, "R11 flag 14 clear");
        do_div(1, 0, 0, 0, 0, 1, "R11 unmasked ovf irq");
        chk("R10 sticky holds", acc_sticky, 1);

        repeat (2) @(negedge clk);
        chk("R9 R11 all irqs seen", exp_q.size(), 0);
        finish_run();
    end
endmodule